// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core and turns them into one request line plus a vector address. Six first-level sources each have a latched flag and an enable bit. These sources are an external pin, two timer overflows, a UART, an I2C unit and a shared multi-function source. The multi-function source has its own flag and vector. It is fed by three second-level sources: timer 2, a time base and a real-time clock. Each of those has its own enable bit and flag.

Software reaches all enables, flags and the global enable through three byte-wide registers on a plain write-strobe / combinational-read port. When at least one enabled flag is pending and the global enable is on, a fixed-priority encoder picks the winner. The block then raises `irq_req` with the matching vector and holds both until the core pulses `irq_ack`. On that acknowledge the block clears the winning first-level flag and drops the global enable, so that a second request cannot nest inside the handler.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all three registers read 0x00, `irq_req` is 0 and `irq_vec` is 0x00.
- R2: Control register 0 (address 0x0B) has the global enable at bit 0. Bits 1, 2 and 3 enable external, timer 0 and timer 1. Bits 4, 5 and 6 are their flags in the same order. Bit 7 ignores writes and reads 0.
- R3: Control register 1 (address 0x1E) has the UART, I2C and multi-function enables at bits 0, 1 and 2, and their flags at bits 4, 5 and 6. The sub-source register (address 0x2F) has the timer 2, time base and real-time clock enables at bits 0, 1 and 2, and their flags at bits 4, 5 and 6. In both registers bits 3 and 7 read 0.
- R4: An event pulse sets its source's flag on the next clock edge whether or not that source is enabled. The flag then stays set until it is cleared.
- R5: A flag takes part in arbitration only when its enable and the global enable are both 1. With the global enable at 0, `irq_req` never rises.
- R6: Among pending enabled flags the winner is the first in the order external, timer 0, timer 1, UART, I2C, multi-function. The vectors are 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 respectively.
- R7: `irq_req` rises one clock after an enabled flag becomes visible. While it is high and no acknowledge arrives, `irq_req` stays high and `irq_vec` does not change, even if a higher-priority flag arrives.
- R8: An `irq_ack` while `irq_req` is high clears the winning flag and the global enable, and drops `irq_req`, all on the same edge. Other flags are kept.
- R9: A register write replaces the flag bits of that register, so writing 0 clears a flag. If an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: The multi-function flag is set on the edge after the set of enabled second-level flags goes from empty to non-empty. Second-level flags are never cleared by hardware, and a masked second-level flag does not set the multi-function flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` (0 for unmapped addresses) |
| ev_ext | input | 1 | External interrupt event pulse |
| ev_tmr0 | input | 1 | Timer 0 overflow pulse |
| ev_tmr1 | input | 1 | Timer 1 overflow pulse |
| ev_uart | input | 1 | UART event pulse |
| ev_i2c | input | 1 | I2C event pulse |
| ev_tmr2 | input | 1 | Timer 2 overflow pulse (second level) |
| ev_tbase | input | 1 | Time base pulse (second level) |
| ev_rtc | input | 1 | Real-time clock pulse (second level) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector address of the pending interrupt |
| irq_ack | input | 1 | Core acknowledge, one cycle |

## Verification
The assertions assume the following about the inputs: `irq_ack` is driven only while `irq_req` is high, or is harmless otherwise; writes to control register 0 are the only thing that may set the global enable again after an acknowledge; event inputs are clean single-cycle pulses. The stimulus drives every input on the falling clock edge and keeps acknowledges as single-cycle pulses issued only after a request has been observed. Between table entries it clears every flag and enable by register writes, so each case starts from a quiet controller. The one case where an event and a clearing write land in the same cycle is built on purpose to exercise the hardware-wins rule.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_CTL0 = 'h0B,
  parameter logic [ADDR_W-1:0] A_CTL1 = 'h1E,
  parameter logic [ADDR_W-1:0] A_SUB  = 'h2F,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ev_ext,
  input  logic              ev_tmr0,
  input  logic              ev_tmr1,
  input  logic              ev_uart,
  input  logic              ev_i2c,
  input  logic              ev_tmr2,
  input  logic              ev_tbase,
  input  logic              ev_rtc,
  output logic              irq_req,
  output logic [7:0]        irq_vec,
  input  logic              irq_ack
);
  localparam int NSRC = 6;
  localparam int NSUB = 3;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_MAX = VEC_BASE + VEC_STEP * (NSRC - 1);

  logic             gie;
  logic [NSRC-1:0]  en, flg;
  logic [NSUB-1:0]  sen, sflg;
  logic             mf_q;
  logic [IDX_W-1:0] win_q;

  wire wr0 = reg_wr && (reg_addr == A_CTL0);
  wire wr1 = reg_wr && (reg_addr == A_CTL1);
  wire wr2 = reg_wr && (reg_addr == A_SUB);
  wire unused_wbits = &{1'b0, reg_wdata[7], reg_wdata[3]};

  wire [NSUB-1:0] sub_ev = {ev_rtc, ev_tbase, ev_tmr2};
  wire            mf_any  = |(sflg & sen);
  wire            mf_rise = mf_any & ~mf_q;
  wire [NSRC-1:0] hw_set  = {mf_rise, ev_i2c, ev_uart, ev_tmr1, ev_tmr0, ev_ext};
  wire            ack_fire = irq_req & irq_ack;

  logic [NSRC-1:0] ack_clr;
  always_comb begin
    ack_clr = '0;
    if (ack_fire) ack_clr[win_q] = 1'b1;
  end

  wire [NSRC-1:0] pend = flg & en & {NSRC{gie}};

  logic [IDX_W-1:0] win_idx;
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) win_idx = IDX_W'(i);
  end

  wire [NSRC-1:0] flg_base = flg & ~ack_clr;
  wire [NSRC-1:0] flg_nxt = hw_set | {
    wr1 ? reg_wdata[6:4] : flg_base[5:3],
    wr0 ? reg_wdata[6:4] : flg_base[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie  <= 1'b0;
      en   <= '0;
      flg  <= '0;
      sen  <= '0;
      sflg <= '0;
      mf_q <= 1'b0;
    end else begin
      flg  <= flg_nxt;
      sflg <= (wr2 ? reg_wdata[6:4] : sflg) | sub_ev;
      mf_q <= mf_any;
      if (wr0) begin
        gie     <= reg_wdata[0];
        en[2:0] <= reg_wdata[3:1];
      end else if (ack_fire) begin
        gie <= 1'b0;
      end
      if (wr1) en[5:3] <= reg_wdata[2:0];
      if (wr2) sen     <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      win_q   <= '0;
    end else if (ack_fire) begin
      irq_req <= 1'b0;
    end else if (!irq_req && |pend) begin
      irq_req <= 1'b1;
      irq_vec <= 8'(VEC_BASE + VEC_STEP * int'(win_idx));
      win_q   <= win_idx;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL0:  reg_rdata = {1'b0, flg[2:0], en[2:0], gie};
      A_CTL1:  reg_rdata = {1'b0, flg[5:3], 1'b0, en[5:3]};
      A_SUB:   reg_rdata = {1'b0, sflg, 1'b0, sen};
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(gie)); // R5
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int'(irq_vec) >= VEC_BASE && int'(irq_vec) <= VEC_MAX
                 && ((int'(irq_vec) - VEC_BASE) % VEC_STEP) == 0)); // R6
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec)); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req); // R8
  AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack && !wr0 |=> !gie); // R8
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ext |=> flg[0]); // R9
  AST_SUB_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && !wr2 |=> sflg >= $past(sflg)); // R10
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam logic [7:0] A0 = 8'h0B, A1 = 8'h1E, AS = 8'h2F;

  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata, irq_vec;
  logic reg_wr = 0, irq_req, irq_ack = 0;
  logic [4:0] ev = 0;
  logic [2:0] sev = 0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_ext(ev[0]), .ev_tmr0(ev[1]), .ev_tmr1(ev[2]), .ev_uart(ev[3]), .ev_i2c(ev[4]),
    .ev_tmr2(sev[0]), .ev_tbase(sev[1]), .ev_rtc(sev[2]),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack));

  // {ev[4:0], en[5:0], gie, exp_req, exp_vec[7:0]}
  localparam logic [20:0] TBL [12] = '{
    {5'b00001, 6'b111111, 1'b1, 1'b1, 8'h04},
    {5'b00010, 6'b111111, 1'b1, 1'b1, 8'h08},
    {5'b00100, 6'b111111, 1'b1, 1'b1, 8'h0C},
    {5'b01000, 6'b111111, 1'b1, 1'b1, 8'h10},
    {5'b10000, 6'b111111, 1'b1, 1'b1, 8'h14},
    {5'b11111, 6'b111111, 1'b1, 1'b1, 8'h04},
    {5'b11110, 6'b111111, 1'b1, 1'b1, 8'h08},
    {5'b11100, 6'b111011, 1'b1, 1'b1, 8'h10},
    {5'b00011, 6'b000000, 1'b1, 1'b0, 8'h00},
    {5'b11111, 6'b111111, 1'b0, 1'b0, 8'h00},
    {5'b10100, 6'b010000, 1'b1, 1'b1, 8'h14},
    {5'b01100, 6'b111111, 1'b1, 1'b1, 8'h0C}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] e, input logic [2:0] s);
    ev = e; sev = s;
    @(negedge clk); ev = 0; sev = 0;
  endtask

  task automatic ack();
    irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    logic [5:0] flags, win;
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A0, d); chk("R1 ctl0", d, 8'h00);
    rd(A1, d); chk("R1 ctl1", d, 8'h00);
    rd(AS, d); chk("R1 sub", d, 8'h00);
    chk("R1 req", {7'b0, irq_req}, 8'h00);
    chk("R1 vec", irq_vec, 8'h00);

    // R2 R3 layout and unused bits
    wr(A0, 8'h8E); rd(A0, d); chk("R2 ctl0 bit7 ignored", d, 8'h0E);
    wr(A1, 8'hFF); rd(A1, d); chk("R3 ctl1 unused bits", d, 8'h77);
    wr(AS, 8'hFF); rd(AS, d); chk("R3 sub unused bits", d, 8'h77);
    chk("R5 no req without gie", {7'b0, irq_req}, 8'h00);
    wr(AS, 8'h00); wr(A1, 8'h00); wr(A0, 8'h00);
    wait_n(2);

    // table walk: R4 R5 R6 R8
    foreach (TBL[k]) begin
      logic [4:0] e; logic [5:0] en; logic g, xr; logic [7:0] xv;
      {e, en, g, xr, xv} = TBL[k];
      wr(A0, {4'b0, en[2:0], g});
      wr(A1, {5'b0, en[5:3]});
      pulse(e, 3'b000);
      @(negedge clk);
      chk($sformatf("R5/R6 req entry %0d", k), {7'b0, irq_req}, {7'b0, xr});
      win = '0;
      if (xr) begin
        chk($sformatf("R6 vec entry %0d", k), irq_vec, xv);
        for (int i = 5; i >= 0; i--) if ((e[i] | 1'b0) && en[i] && i < 5) win = 6'(1) << i;
        ack();
        chk($sformatf("R8 req drop entry %0d", k), {7'b0, irq_req}, 8'h00);
        rd(A0, d); chk($sformatf("R8 gie cleared entry %0d", k), {7'b0, d[0]}, 8'h00);
      end
      flags = {1'b0, e} & ~win;
      rd(A0, d); chk($sformatf("R4 flags0 entry %0d", k), {5'b0, d[6:4]}, {5'b0, flags[2:0]});
      rd(A1, d); chk($sformatf("R4 flags1 entry %0d", k), {5'b0, d[6:4]}, {5'b0, flags[5:3]});
      wr(A0, 8'h00); wr(A1, 8'h00);
      @(negedge clk);
    end

    // R7 vector held while a higher priority flag arrives
    wr(A0, 8'h0F); wr(A1, 8'h07);
    pulse(5'b10000, 3'b000);
    @(negedge clk);
    chk("R7 req rise", {7'b0, irq_req}, 8'h01);
    pulse(5'b00001, 3'b000);
    wait_n(2);
    chk("R7 vec held", irq_vec, 8'h14);
    chk("R7 req held", {7'b0, irq_req}, 8'h01);
    ack();
    rd(A0, d); chk("R8 other flag kept", d, 8'h1E);
    rd(A1, d); chk("R8 winner cleared", d, 8'h07);
    wr(A0, 8'h13);
    @(negedge clk);
    chk("R6 next vec", irq_vec, 8'h04);
    ack();
    wr(A0, 8'h00); wr(A1, 8'h00);

    // R9 software clear and collision
    pulse(5'b01000, 3'b000);
    rd(A1, d); chk("R9 flag set", d, 8'h10);
    wr(A1, 8'h00);
    rd(A1, d); chk("R9 sw clear", d, 8'h00);
    ev = 5'b01000; wr(A1, 8'h00); ev = 0;
    rd(A1, d); chk("R9 hw set wins", d, 8'h10);
    wr(A1, 8'h00);

    // R10 multi-function aggregation
    wr(AS, 8'h02); wr(A1, 8'h04); wr(A0, 8'h01);
    pulse(5'b0, 3'b010);
    wait_n(2);
    chk("R10 mf req", {7'b0, irq_req}, 8'h01);
    chk("R10 mf vec", irq_vec, 8'h18);
    ack();
    rd(AS, d); chk("R10 sub flag kept", d, 8'h22);
    rd(A1, d); chk("R10 mf flag cleared", d, 8'h04);
    wr(A0, 8'h01);
    wait_n(3);
    chk("R10 no retrigger", {7'b0, irq_req}, 8'h00);
    wr(AS, 8'h00);
    pulse(5'b0, 3'b001);
    wait_n(3);
    rd(AS, d); chk("R10 masked sub flag", d, 8'h10);
    rd(A1, d); chk("R10 masked no mf", d, 8'h04);
    wr(AS, 8'h11);
    wait_n(2);
    chk("R10 enable late req", {7'b0, irq_req}, 8'h01);
    chk("R10 enable late vec", irq_vec, 8'h18);
    ack();
    wr(AS, 8'h00); wr(A1, 8'h00); wr(A0, 8'h00);
    wait_n(2);
    finish_up();
  end
endmodule